// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst in a synchronous cache SRAM. A burst starts when either of two active-low address strobes is sampled low: one strobe is driven by the processor and the other by the cache controller. A single active-high enable gates both strobes. At that edge the block captures the full word address. The upper bits stay fixed for the rest of the burst. The two low bits then step through the burst each time the active-low advance input is sampled low.

Two orderings are supported. With the order-select input high, beats follow the interleaved pattern: the start offset XOR the beat count. With it low, beats follow a linear pattern: the start offset plus the beat count, modulo four. The order is sampled with the strobe and applies to the whole burst. It resets to interleaved, which matches an unconnected, pulled-high select pin. All inputs are sampled on the rising clock edge. The outputs come straight from registers, so a new address appears in the cycle after the edge that caused it.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and after its release, before any load, addr_o is 0, beat_o is 0 and last_o is 0.
- R2: If en_i is high and ads_cpu_ni or ads_ctl_ni is low at a rising edge, then after that edge addr_o equals the sampled addr_i and beat_o is 0.
- R3: If en_i is low at an edge, both strobes are ignored. The address and beat then behave as if neither strobe were asserted.
- R4: If both strobes are low in the same cycle, the processor strobe wins. The result is one load, with beat_o 0. A strobe also takes priority over a simultaneous advance.
- R5: If adv_ni is low at an edge without a load, beat_o increments by 1 modulo 4. It wraps from 3 to 0 and keeps cycling while advance is held.
- R6: With mode_i = 0 (linear) sampled at the load, addr_o[1:0] = (start + beat_o) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R7: With mode_i = 1 (interleaved) sampled at the load, addr_o[1:0] = start XOR beat_o. For example, start 1 gives 1, 0, 3, 2, and start 2 gives 2, 3, 0, 1.
- R8: mode_i only matters at a load. Changing it during a burst does not change that burst's order.
- R9: addr_o[ADDR_W-1:2] stays constant between loads, whatever addr_i does.
- R10: With no load and adv_ni high, addr_o and beat_o hold their values.
- R11: last_o is high exactly when beat_o is 3, the final beat before the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable that gates both strobes, active high |
| ads_cpu_ni | input | 1 | Processor address strobe, active low, higher priority |
| ads_ctl_ni | input | 1 | Cache-controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Start word address |
| addr_o | output | ADDR_W | Word address to the memory core |
| beat_o | output | BURST_W | Current beat position in the burst |
| last_o | output | 1 | High on the final beat |

## Verification
The assertions assume that en_i, both strobes, adv_ni, mode_i and addr_i have known values at every rising edge after reset. This matters because the checker derives its load and step conditions from these inputs and keeps its own record of the order sampled at each load. The bench drives every input on the falling edge, only with defined levels. It holds inputs idle throughout reset, so each edge the checker sees is a clean load, step or hold.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    EV_IDLE     = 2'd0,
    EV_STEP     = 2'd1,
    EV_LOAD_CPU = 2'd2,
    EV_LOAD_CTL = 2'd3
  } burst_evt_e;
endpackage

// File: rtl/burst_strobe_arb.sv
`timescale 1ns/1ps
module burst_strobe_arb
  import burst_pkg::*;
(
  input  logic       en_i,
  input  logic       ads_cpu_ni,
  input  logic       ads_ctl_ni,
  input  logic       adv_ni,
  output burst_evt_e evt_o
);
  logic cpu_req, ctl_req;

  assign cpu_req = en_i & ~ads_cpu_ni;
  assign ctl_req = en_i & ~ads_ctl_ni;

  // processor strobe first, then controller strobe, then advance
  always_comb begin
    if (cpu_req)      evt_o = EV_LOAD_CPU;
    else if (ctl_req) evt_o = EV_LOAD_CTL;
    else if (!adv_ni) evt_o = EV_STEP;
    else              evt_o = EV_IDLE;
  end
endmodule

// File: rtl/burst_order_map.sv
`timescale 1ns/1ps
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  input  burst_order_e       order_i,
  output logic [BURST_W-1:0] offs_o
);
  logic [BURST_W-1:0] lin_offs;
  logic [BURST_W-1:0] ilv_offs;

  assign lin_offs = start_i + beat_i;

  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
    assign ilv_offs[b] = start_i[b] ^ beat_i[b];
  end

  assign offs_o = (order_i == ORD_INTERLEAVE) ? ilv_offs : lin_offs;
endmodule

// File: rtl/burst_ctr.sv
`timescale 1ns/1ps
module burst_ctr
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2,
  localparam int HiW    = ADDR_W - BURST_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  burst_evt_e         evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               mode_i,
  output logic [HiW-1:0]     hi_o,
  output logic [BURST_W-1:0] start_o,
  output logic [BURST_W-1:0] beat_o,
  output burst_order_e       order_o
);
  logic load;

  assign load = (evt_i == EV_LOAD_CPU) || (evt_i == EV_LOAD_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o    <= '0;
      start_o <= '0;
      beat_o  <= '0;
      order_o <= ORD_INTERLEAVE;  // unconnected select reads high
    end else if (load) begin
      hi_o    <= addr_i[ADDR_W-1:BURST_W];
      start_o <= addr_i[BURST_W-1:0];
      beat_o  <= '0;
      order_o <= burst_order_e'(mode_i);
    end else if (evt_i == EV_STEP) begin
      beat_o  <= beat_o + 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               ads_cpu_ni,
  input  logic               ads_ctl_ni,
  input  logic               adv_ni,
  input  logic               mode_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [BURST_W-1:0] beat_o,
  output logic               last_o
);
  localparam int HiW = ADDR_W - BURST_W;

  burst_evt_e         evt;
  logic [HiW-1:0]     hi_q;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] beat_q;
  burst_order_e       order_q;
  logic [BURST_W-1:0] offs;

  burst_strobe_arb u_arb (
    .en_i       (en_i),
    .ads_cpu_ni (ads_cpu_ni),
    .ads_ctl_ni (ads_ctl_ni),
    .adv_ni     (adv_ni),
    .evt_o      (evt)
  );

  burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .addr_i  (addr_i),
    .mode_i  (mode_i),
    .hi_o    (hi_q),
    .start_o (start_q),
    .beat_o  (beat_q),
    .order_o (order_q)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order_q),
    .offs_o  (offs)
  );

  assign addr_o = {hi_q, offs};
  assign beat_o = beat_q;
  assign last_o = &beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
module burst_addr_gen_chk #(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               ads_cpu_ni,
  input logic               ads_ctl_ni,
  input logic               adv_ni,
  input logic               mode_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [ADDR_W-1:0]  addr_o,
  input logic [BURST_W-1:0] beat_o,
  input logic               last_o
);
  logic ld, step, idle, mode_seen;

  assign ld   = en_i && (!ads_cpu_ni || !ads_ctl_ni);
  assign step = !ld && !adv_ni;
  assign idle = !ld && adv_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mode_seen <= 1'b1;
    else if (ld)  mode_seen <= mode_i;
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (addr_o == $past(addr_i)) && (beat_o == '0));

  p_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && adv_ni) |=> $stable(addr_o) && $stable(beat_o));

  p_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ads_cpu_ni && !ads_ctl_ni && !adv_ni) |=> (beat_o == '0));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (beat_o == BURST_W'($past(beat_o) + 1'b1)));

  p_linear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !mode_seen) |=>
      (addr_o[BURST_W-1:0] == BURST_W'($past(addr_o[BURST_W-1:0]) + 1'b1)));

  p_ilv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_seen) |=>
      ((addr_o[BURST_W-1:0] ^ $past(addr_o[BURST_W-1:0])) == (beat_o ^ $past(beat_o))));

  p_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(addr_o[ADDR_W-1:BURST_W]));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(addr_o) && $stable(beat_o));

  p_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && step) |=> (!last_o && beat_o == '0));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .ads_cpu_ni (ads_cpu_ni),
  .ads_ctl_ni (ads_ctl_ni),
  .adv_ni     (adv_ni),
  .mode_i     (mode_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .beat_o     (beat_o),
  .last_o     (last_o)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int AW = 15;
  localparam int BW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b1;
  logic          ads_cpu_ni = 1'b1;
  logic          ads_ctl_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          mode_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] beat_o;
  logic          last_o;

  int checks = 0;
  int fails  = 0;

  // bench model of the burst state
  logic [AW-BW-1:0] m_hi = '0;
  logic [BW-1:0]    m_start = '0;
  logic [BW-1:0]    m_beat = '0;
  logic             m_ilv = 1'b1;

  logic [AW-1:0] q_addr[$];
  logic [BW-1:0] q_beat[$];
  string         q_tag[$];

  always #10 clk_i = ~clk_i;  // 50 MHz

  burst_addr_gen #(.ADDR_W(AW), .BURST_W(BW)) u_burst_addr_gen (
    .clk_i, .rst_ni, .en_i, .ads_cpu_ni, .ads_ctl_ni,
    .adv_ni, .mode_i, .addr_i, .addr_o, .beat_o, .last_o
  );

  function automatic logic [AW-1:0] model_addr();
    logic [BW-1:0] lo;
    lo = m_ilv ? (m_start ^ m_beat) : BW'(m_start + m_beat);
    return {m_hi, lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic [BW-1:0] eb);
    logic el;
    el = (eb == 2'd3);
    checks++;
    if (addr_o !== ea || beat_o !== eb || last_o !== el) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d last=%b expected addr=%h beat=%0d last=%b",
               tag, addr_o, beat_o, last_o, ea, eb, el);
    end
  endtask

  // driver: apply one cycle of stimulus, update model, queue the expectation
  task automatic cyc(input logic cpu_n, input logic ctl_n, input logic adv_n,
                     input logic mode, input logic en, input logic [AW-1:0] a,
                     input string tag);
    ads_cpu_ni = cpu_n; ads_ctl_ni = ctl_n; adv_ni = adv_n;
    mode_i = mode; en_i = en; addr_i = a;
    @(posedge clk_i);
    if (en && (!cpu_n || !ctl_n)) begin
      m_hi = a[AW-1:BW]; m_start = a[BW-1:0]; m_beat = '0; m_ilv = mode;
    end else if (!adv_n) begin
      m_beat = m_beat + 1'b1;
    end
    q_addr.push_back(model_addr());
    q_beat.push_back(m_beat);
    q_tag.push_back(tag);
    @(negedge clk_i);
  endtask

  // monitor: compare after every edge
  always @(posedge clk_i) begin
    #2;
    if (q_addr.size() > 0) check(q_tag.pop_front(), q_addr.pop_front(), q_beat.pop_front());
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", '0, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", '0, '0);

    // R2 processor strobe, R6 linear order from start 1, R5 wrap, R11 last
    cyc(0, 1, 1, 0, 1, 15'h1235, "R2 cpu load");
    cyc(1, 1, 0, 0, 1, 15'h0000, "R6 lin beat1");
    cyc(1, 1, 0, 0, 1, 15'h0000, "R6 lin beat2");
    cyc(1, 1, 0, 0, 1, 15'h0000, "R11 lin beat3 last");
    cyc(1, 1, 0, 0, 1, 15'h0000, "R5 lin wrap");
    cyc(1, 1, 0, 0, 1, 15'h0000, "R5 lin keeps cycling");

    // R2 controller strobe, R7 interleaved from start 1
    cyc(1, 0, 1, 1, 1, 15'h2A01, "R2 ctl load");
    cyc(1, 1, 0, 1, 1, 15'h0000, "R7 ilv beat1");
    cyc(1, 1, 0, 1, 1, 15'h0000, "R7 ilv beat2");
    cyc(1, 1, 0, 1, 1, 15'h0000, "R7 ilv beat3");
    cyc(1, 1, 0, 1, 1, 15'h0000, "R5 ilv wrap");

    // R7 interleaved from start 2
    cyc(0, 1, 1, 1, 1, 15'h7FFE, "R2 load start2");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, 1, 15'h0000, "R7 ilv start2");

    // R10 hold and R9 upper bits ignore addr_i
    cyc(1, 1, 1, 0, 1, 15'h5555, "R10 hold");
    cyc(1, 1, 1, 1, 1, 15'h2AAA, "R9 addr_i ignored");

    // R3 strobes ignored while disabled
    cyc(0, 0, 1, 0, 0, 15'h1111, "R3 disabled hold");
    cyc(0, 1, 0, 0, 0, 15'h2222, "R3 disabled step");

    // R4 both strobes plus advance: single load at beat 0
    cyc(0, 0, 0, 0, 1, 15'h4C03, "R4 both strobes");
    cyc(1, 1, 0, 1, 1, 15'h0000, "R8 mode change ignored");
    cyc(1, 1, 0, 1, 1, 15'h0000, "R8 mode change ignored");
    cyc(0, 1, 0, 1, 1, 15'h0102, "R4 strobe beats advance");

    // R5 long advance run
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 1, 15'h0000, "R5 long run");
    cyc(1, 1, 1, 0, 1, 15'h0000, "R10 idle");

    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule